// File: doc/BRIEF.md
# Entropy Collection Controller

This block is the register front end and bit gatherer of a true random number generator. Software on a plain 32-bit register bus programs a sample spacing, then arms a collection through a control register. Every write to that register carries its own per-bit write-enable mask in the upper half, so a field changes only when it is explicitly enabled. While a collection runs, the block takes one raw entropy bit from an external oscillator source per programmed period. It packs the bits into eight 32-bit result words and clears its own start flag when the requested amount has been gathered.

Software starts a run, polls the start flag until it reads zero, reads the result words and finally disarms the generator with one masked write. A reset-control register lets software return the control state and the result words to their reset values without touching the hardware reset. The oscillator speed field is not used inside the block. It is forwarded on a two-bit output for the external oscillator.

Top module: `trng_ctrl`

## Requirements
- R1: A write to offset 0x400 updates control bit i (i in 0..5) only when write-data bit 16+i is 1. Other bits keep their value, and bits 31:6 of the register read as zero.
- R2: The control fields are start at bit 0, enable at bit 1, oscillator speed at bits 3:2 and length code at bits 5:4. The `ring_sel` output always equals bits 3:2.
- R3: Offset 0x404 holds a 16-bit sample spacing, 100 after reset, read back as written. With spacing P (0 counts as 1), the first sample of a run is taken P cycles after the start edge and each later sample P cycles after the previous one. Nothing is sampled unless start and enable are both 1.
- R4: Sample n of a run (n from 0) is stored in word n/32, bit n%32. Word w reads at offset 0x410+4w for w in 0..7.
- R5: A run gathers 64*(L+1) bits for length code L. Start reads 1 up to the edge that stores the last bit and reads 0 from that edge on, while enable stays 1.
- R6: Word w reads zero whenever w >= 2*(L+1) for the current length code L. The stored value reappears when L grows again.
- R7: If start is 1 while enable is 0, start clears on the next clock. No sample is taken and the result words keep their contents.
- R8: A masked write that raises start from 0 with enable 1 clears all result words in that same clock.
- R9: A masked write clearing start and enable halts sampling at once. The bits gathered up to and including that edge stay readable.
- R10: When a run completes in the same clock as a control write that does not enable bit 0, the write's enabled fields take effect and start still clears.
- R11: Writing 1 to bit 1 of offset 0x004 returns the control register to 0, the spacing to 100 and all result words to 0, even mid-run. Offset 0x004 reads as 0.
- R12: Reads of undefined offsets (for example 0x408 and 0x430) return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data, mask in bits 31:16 for the control register |
| reg_rdata | output | 32 | Read data, valid in the cycle of a read access |
| entropy_bit | input | 1 | Raw bit from the external oscillator |
| ring_sel | output | 2 | Oscillator speed selection forwarded outward |

## Verification
Two functions can land on the same clock edge here: the self-clear of start when the last bit is stored, and a software masked write to the control register. The bench provokes the collision by timing a write that changes only the oscillator speed so that it is captured on exactly the completion edge. It then checks that the new speed is applied, that start reads zero and that the last result word is complete. A second race, the stop write landing on a sampling edge, is judged by checking that the sample on that edge is kept.

// File: rtl/trng_ctrl_pkg.sv
package trng_ctrl_pkg;

    localparam logic [11:0] OFF_SRST = 12'h004;
    localparam logic [11:0] OFF_CTL  = 12'h400;
    localparam logic [11:0] OFF_SCNT = 12'h404;
    localparam logic [11:0] OFF_DATA = 12'h410;

    localparam int CTL_BITS = 6;
    localparam int SRST_BIT = 1;

    typedef struct packed {
        logic [1:0] len;
        logic [1:0] ring;
        logic       en;
        logic       start;
    } ctl_t;

    localparam ctl_t CTL_RST = '0;

endpackage

// File: rtl/trng_ctrl_regs.sv
module trng_ctrl_regs
    import trng_ctrl_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 16,
    parameter int SCNT_RST = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_scnt,
    input  logic              soft_rst,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    output ctl_t              ctl,
    output logic [CNT_W-1:0]  scnt,
    output logic              start_pulse
);

    localparam int MASK_LSB = DATA_W / 2;

    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] scnt;
    } regs_t;

    localparam regs_t REGS_RST = '{ctl: CTL_RST, scnt: CNT_W'(SCNT_RST)};

    regs_t st_d, st_q;
    ctl_t  base, wmask, wval;
    logic  pulse_d;
    logic  unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        st_d    = st_q;
        base    = st_q.ctl;
        wmask   = ctl_t'(wdata[MASK_LSB +: CTL_BITS]);
        wval    = ctl_t'(wdata[CTL_BITS-1:0]);
        pulse_d = 1'b0;

        // a start left standing without enable drops on the next clock
        if (!st_q.ctl.en) begin
            base.start = 1'b0;
        end

        st_d.ctl = base;
        if (wr_ctl) begin
            st_d.ctl = ctl_t'((base & ~wmask) | (wval & wmask));
            pulse_d  = wmask.start && wval.start && !base.start && st_d.ctl.en;
        end

        // completion always wins on the start bit
        if (done) begin
            st_d.ctl.start = 1'b0;
        end

        if (wr_scnt) begin
            st_d.scnt = wdata[CNT_W-1:0];
        end

        if (soft_rst) begin
            st_d    = REGS_RST;
            pulse_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= REGS_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl         = st_q.ctl;
    assign scnt        = st_q.scnt;
    assign start_pulse = pulse_d;

endmodule

// File: rtl/trng_sample_timer.sv
module trng_sample_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic [CNT_W-1:0] period,
    output logic             sample
);

    typedef struct packed {
        logic [CNT_W-1:0] tick;
    } tmr_t;

    tmr_t             st_d, st_q;
    logic [CNT_W-1:0] last;
    logic             sample_d;

    always_comb begin
        st_d     = st_q;
        sample_d = 1'b0;
        last     = (period == '0) ? '0 : period - 1'b1;

        if (!busy) begin
            st_d.tick = '0;
        end else if (st_q.tick >= last) begin
            st_d.tick = '0;
            sample_d  = 1'b1;
        end else begin
            st_d.tick = st_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample = sample_d;

endmodule

// File: rtl/trng_collector.sv
module trng_collector #(
    parameter int DATA_W  = 32,
    parameter int N_WORDS = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           sample,
    input  logic                           bit_in,
    input  logic [1:0]                     len,
    output logic [N_WORDS-1:0][DATA_W-1:0] words,
    output logic                           done
);

    localparam int TOTAL  = DATA_W * N_WORDS;
    localparam int SEG    = TOTAL / 4;
    localparam int CNT_W  = $clog2(TOTAL) + 1;
    localparam int BIDX_W = $clog2(DATA_W);
    localparam int WIDX_W = $clog2(N_WORDS);

    typedef struct packed {
        logic [N_WORDS-1:0][DATA_W-1:0] words;
        logic [CNT_W-1:0]               cnt;
    } col_t;

    col_t             st_d, st_q;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] next_cnt;
    logic             done_d;

    always_comb begin
        st_d     = st_q;
        done_d   = 1'b0;
        target   = CNT_W'(SEG) * (CNT_W'(len) + CNT_W'(1));
        next_cnt = st_q.cnt + 1'b1;

        if (clear) begin
            st_d = '0;
        end else if (sample) begin
            if (st_q.cnt < CNT_W'(TOTAL)) begin
                st_d.words[st_q.cnt[BIDX_W +: WIDX_W]][st_q.cnt[BIDX_W-1:0]] = bit_in;
                st_d.cnt = next_cnt;
            end
            done_d = (next_cnt >= target);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words = st_q.words;
    assign done  = done_d;

endmodule

// File: rtl/trng_ctrl.sv
module trng_ctrl
    import trng_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int N_WORDS  = 8,
    parameter int CNT_W    = 16,
    parameter int SCNT_RST = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              entropy_bit,
    output logic [1:0]        ring_sel
);

    localparam int WIDX_W = $clog2(N_WORDS);
    localparam int WCNT_W = WIDX_W + 1;
    localparam int STEP   = DATA_W / 8;

    localparam logic [ADDR_W-1:0] A_SRST  = ADDR_W'(OFF_SRST);
    localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(OFF_CTL);
    localparam logic [ADDR_W-1:0] A_SCNT  = ADDR_W'(OFF_SCNT);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_DEND  = ADDR_W'(OFF_DATA + STEP * N_WORDS);

    logic                           wr_ctl, wr_scnt, soft_rst;
    ctl_t                           ctl_q;
    logic [CNT_W-1:0]               scnt_q;
    logic                           start_pulse;
    logic                           busy;
    logic                           sample;
    logic                           done;
    logic [N_WORDS-1:0][DATA_W-1:0] words;
    logic [N_WORDS-1:0][DATA_W-1:0] vis;
    logic [WCNT_W-1:0]              n_vis;
    logic [ADDR_W-1:0]              data_off;
    logic [DATA_W-1:0]              rdata_d;

    assign wr_ctl   = reg_en && reg_wr && (reg_addr == A_CTL);
    assign wr_scnt  = reg_en && reg_wr && (reg_addr == A_SCNT);
    assign soft_rst = reg_en && reg_wr && (reg_addr == A_SRST) && reg_wdata[SRST_BIT];
    assign busy     = ctl_q.start && ctl_q.en;

    trng_ctrl_regs #(
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .SCNT_RST (SCNT_RST)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctl      (wr_ctl),
        .wr_scnt     (wr_scnt),
        .soft_rst    (soft_rst),
        .wdata       (reg_wdata),
        .done        (done),
        .ctl         (ctl_q),
        .scnt        (scnt_q),
        .start_pulse (start_pulse)
    );

    trng_sample_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (busy),
        .period (scnt_q),
        .sample (sample)
    );

    trng_collector #(
        .DATA_W  (DATA_W),
        .N_WORDS (N_WORDS)
    ) u_col (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_pulse || soft_rst),
        .sample (sample),
        .bit_in (entropy_bit),
        .len    (ctl_q.len),
        .words  (words),
        .done   (done)
    );

    // words past the selected length are hidden, not erased
    assign n_vis = (WCNT_W'(ctl_q.len) + WCNT_W'(1)) * WCNT_W'(N_WORDS / 4);

    for (genvar w = 0; w < N_WORDS; w++) begin : g_vis
        assign vis[w] = (WCNT_W'(w) < n_vis) ? words[w] : '0;
    end

    assign data_off = reg_addr - A_DATA;

    always_comb begin
        rdata_d = '0;
        if (reg_en && !reg_wr && (reg_addr[1:0] == 2'b00)) begin
            if (reg_addr == A_CTL) begin
                rdata_d = DATA_W'(ctl_q);
            end else if (reg_addr == A_SCNT) begin
                rdata_d = DATA_W'(scnt_q);
            end else if (reg_addr >= A_DATA && reg_addr < A_DEND) begin
                rdata_d = vis[data_off[2 +: WIDX_W]];
            end
        end
    end

    assign reg_rdata = rdata_d;
    assign ring_sel  = ctl_q.ring;

endmodule

// File: rtl/trng_ctrl_chk.sv
module trng_ctrl_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_en,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [1:0]        ring_sel,
    input logic [5:0]        ctl,
    input logic              sample,
    input logic              done
);

    localparam int MSK = DATA_W / 2;

    logic c_wr_ctl, c_srst, c_rd_hole;

    assign c_wr_ctl  = reg_en && reg_wr && (reg_addr == ADDR_W'(12'h400));
    assign c_srst    = reg_en && reg_wr && (reg_addr == ADDR_W'(12'h004)) && reg_wdata[1];
    assign c_rd_hole = reg_en && !reg_wr && (reg_addr == ADDR_W'(12'h408));

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr_ctl && reg_wdata[MSK+1 +: 5] == 5'd0) |=> (ctl[5:1] == $past(ctl[5:1]))); // R1

    AST_RING_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr_ctl && reg_wdata[MSK+3:MSK+2] == 2'b11) |=> (ring_sel == $past(reg_wdata[3:2]))); // R2

    AST_SAMPLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (ctl[0] && ctl[1])); // R3

    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !ctl[0]); // R5

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[0] && !ctl[1] && !c_wr_ctl) |=> !ctl[0]); // R7

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        c_srst |=> (ctl == 6'd0)); // R11

    AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        c_rd_hole |-> (reg_rdata == '0)); // R12

endmodule

bind trng_ctrl trng_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ring_sel  (ring_sel),
    .ctl       (ctl_q),
    .sample    (sample),
    .done      (done)
);

// File: tb/trng_ctrl_tb.sv
module trng_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        entropy_bit = 1'b0;
    logic [1:0]  ring_sel;

    int total = 0;
    int bad = 0;
    bit rd_act = 0;
    bit arm = 0;
    int eidx = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    trng_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_en      (reg_en),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .entropy_bit (entropy_bit),
        .ring_sel    (ring_sel)
    );

    function automatic logic ent(int j);
        logic [31:0] h;
        h = 32'(j) * 32'h9E3779B1;
        return h[13] ^ h[27] ^ h[5];
    endfunction

    // expected word w after nbits samples taken at spacing p
    function automatic logic [31:0] exp_word(int p, int nbits, int w);
        logic [31:0] v;
        v = '0;
        for (int b = 0; b < 32; b++) begin
            if (w * 32 + b < nbits) v[b] = ent((w * 32 + b + 1) * p);
        end
        return v;
    endfunction

    task automatic check(logic [31:0] got, logic [31:0] exp, string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    // entropy source: value before edge j (counted from the start edge) is ent(j)
    always @(posedge clk) begin
        if (arm) begin
            eidx = 0;
            arm  = 0;
        end else begin
            eidx++;
        end
        #1 entropy_bit = ent(eidx + 1);
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rd_act && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(reg_rdata, e, t);
        end
    end

    task automatic op_wr(logic [11:0] a, logic [31:0] d, bit arm_it = 0);
        @(posedge clk); #1;
        reg_en = 1; reg_wr = 1; reg_addr = a; reg_wdata = d; rd_act = 0;
        if (arm_it) arm = 1;
    endtask

    task automatic op_rd(logic [11:0] a, logic [31:0] exp, string tag);
        @(posedge clk); #1;
        reg_en = 1; reg_wr = 0; reg_addr = a; reg_wdata = '0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_act = 1;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(posedge clk); #1;
            reg_en = 0; reg_wr = 0; rd_act = 0;
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R5 watchdog: got=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        op_rd(12'h400, 32'h0, "R2 control after reset");
        op_rd(12'h404, 32'd100, "R3 spacing after reset");
        op_rd(12'h410, 32'h0, "R4 word0 after reset");
        op_rd(12'h004, 32'h0, "R11 reset register reads zero");
        idle(1);

        // masked writes
        op_wr(12'h400, 32'h000C_003F);
        op_rd(12'h400, 32'h0000_000C, "R1 only speed bits enabled");
        check({30'b0, ring_sel}, 32'd3, "R2 ring_sel follows speed");
        op_wr(12'h400, 32'h0000_FFFF);
        op_rd(12'h400, 32'h0000_000C, "R1 empty mask changes nothing");
        op_wr(12'h400, 32'h000C_0000);
        op_rd(12'h400, 32'h0, "R1 speed cleared");
        check({30'b0, ring_sel}, 32'd0, "R2 ring_sel back to zero");

        // undefined offsets
        op_wr(12'h408, 32'hFFFF_FFFF);
        op_wr(12'h430, 32'hFFFF_FFFF);
        op_rd(12'h408, 32'h0, "R12 hole 0x408 reads zero");
        op_rd(12'h430, 32'h0, "R12 hole 0x430 reads zero");
        op_rd(12'h404, 32'd100, "R12 spacing untouched");
        op_rd(12'h400, 32'h0, "R12 control untouched");

        // run 1: spacing 3, 64 bits
        op_wr(12'h404, 32'd3);
        op_rd(12'h404, 32'd3, "R3 spacing written");
        op_wr(12'h400, 32'h0033_0003, 1);
        idle(191);
        op_rd(12'h400, 32'h3, "R5 start still set before last bit");
        op_rd(12'h400, 32'h2, "R5 start cleared at last bit");
        op_rd(12'h410, exp_word(3, 64, 0), "R4 run1 word0 spacing 3");
        op_rd(12'h414, exp_word(3, 64, 1), "R4 run1 word1 spacing 3");
        for (int w = 2; w < 8; w++) op_rd(12'h410 + 12'(4 * w), 32'h0, "R6 run1 hidden word");
        idle(1);

        // run 2: spacing 0 treated as 1, 128 bits
        op_wr(12'h404, 32'd0);
        op_rd(12'h404, 32'd0, "R3 zero spacing stored");
        op_wr(12'h400, 32'h0033_0013, 1);
        op_rd(12'h410, 32'h0, "R8 words cleared at start");
        idle(126);
        op_rd(12'h400, 32'h13, "R5 start set before bit 128");
        op_rd(12'h400, 32'h12, "R5 start cleared after bit 128");
        for (int w = 0; w < 4; w++) op_rd(12'h410 + 12'(4 * w), exp_word(1, 128, w), "R3 R4 run2 word spacing zero");
        op_rd(12'h420, 32'h0, "R6 run2 word4 hidden");
        idle(1);

        // start without enable
        op_wr(12'h400, 32'h0003_0000);
        op_wr(12'h400, 32'h0001_0001);
        op_rd(12'h400, 32'h11, "R7 start visible for one clock");
        op_rd(12'h400, 32'h10, "R7 start dropped without enable");
        op_rd(12'h410, exp_word(1, 128, 0), "R7 words kept");
        idle(1);

        // stop mid-run: start at edge 0, stop captured at edge 10
        op_wr(12'h400, 32'h0033_0003, 1);
        idle(9);
        op_wr(12'h400, 32'h0003_0000);
        op_rd(12'h400, 32'h0, "R9 stop clears start and enable");
        idle(5);
        op_rd(12'h410, exp_word(1, 10, 0), "R9 ten samples kept");
        op_rd(12'h414, 32'h0, "R9 no sampling after stop");
        idle(1);

        // completion colliding with a speed write
        op_wr(12'h404, 32'd2);
        op_wr(12'h400, 32'h0033_0003, 1);
        idle(127);
        op_wr(12'h400, 32'h000C_0008);
        op_rd(12'h400, 32'h0A, "R10 write applied and start cleared");
        check({30'b0, ring_sel}, 32'd2, "R10 R2 speed from colliding write");
        op_rd(12'h414, exp_word(2, 64, 1), "R10 last word complete");
        idle(1);

        // software reset mid-run
        op_wr(12'h404, 32'd5);
        op_wr(12'h400, 32'h0033_0033, 1);
        idle(20);
        op_wr(12'h004, 32'h0000_0002);
        op_rd(12'h400, 32'h0, "R11 control cleared");
        op_rd(12'h404, 32'd100, "R11 spacing restored");
        op_rd(12'h410, 32'h0, "R11 word0 cleared");
        check({30'b0, ring_sel}, 32'd0, "R11 ring_sel cleared");
        idle(1);

        // full 256-bit run at spacing 1
        op_wr(12'h404, 32'd1);
        op_wr(12'h400, 32'h003F_003B, 1);
        idle(255);
        op_rd(12'h400, 32'h3B, "R5 256-bit run still active");
        op_rd(12'h400, 32'h3A, "R5 256-bit run done");
        for (int w = 0; w < 8; w++) op_rd(12'h410 + 12'(4 * w), exp_word(1, 256, w), "R4 full run word");
        op_wr(12'h400, 32'h0030_0000);
        op_rd(12'h418, 32'h0, "R6 word2 hidden at length 64");
        op_rd(12'h414, exp_word(1, 256, 1), "R6 word1 still shown");
        op_wr(12'h400, 32'h0030_0030);
        op_rd(12'h418, exp_word(1, 256, 2), "R6 word2 shown again");
        idle(3);

        finish_run();
    end

endmodule